// File: doc/BRIEF.md
# I2C Serial Memory Slave Protocol Engine

This block is the bus-facing half of a serial memory. It watches oversampled SCL and SDA lines in the system clock domain, finds START and STOP conditions, and decodes the control byte. It accepts a two-byte address into one address pointer that all address spaces share, and acknowledges bytes by pulling SDA low. For reads it returns data taken from a memory read port. For writes it passes each received byte to a page-buffer interface. A STOP then turns the collected bytes into a single commit pulse.

Two control codes select between the memory array and a secondary space. The secondary space holds one-time-programmable bytes and a two-bit block-protect register. The engine reads an external busy flag. While that flag is high it refuses every control byte, so a bus master can poll for the end of an internal write. The block-protect register decides whether an array write may commit.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the SDA pull output is released and no page-buffer push or commit pulse is issued until a transfer occurs.
- R2: The control byte is received MSB first. Bits 7:5 must be 101, bits 3:1 must equal the STRAP parameter, bit 4 selects the space (0 array, 1 secondary) and bit 0 set means read. Any other control byte is not acknowledged, and the engine ignores the bus until the next START.
- R3: Every accepted byte of a write is acknowledged on the 9th clock. Each data byte is pushed with its target address. A STOP that follows at least one data byte produces one commit pulse, and a STOP with no data byte produces none.
- R4: While the busy input is high, a control byte is not acknowledged. Once busy is low again, the same control byte is acknowledged.
- R5: A repeated START after the two address bytes ends the write without a commit and leaves the pointer at the sent address, so a following read returns that location.
- R6: During a read, each master ACK advances the pointer and sends the next byte. In the array space the pointer rolls from 1FFFh to 0000h.
- R7: Array write addresses advance only within the aligned 32-byte page and wrap to the page start.
- R8: The protect register sits at address 0401h in the secondary space. It reads as {0000, P1, P0, 00}. A write there updates only bits 3:2 on STOP and issues no commit.
- R9: An array write commit is suppressed when any target byte is protected. P1:P0 = 00 protects nothing, 01 protects 1800h–1FFFh, 10 protects 1000h–1FFFh and 11 protects the whole array.
- R10: Data bytes that target protected addresses are still acknowledged.
- R11: A read that carries no address starts at the location after the last byte sent.
- R12: The secondary space is read through the same pointer, and the pointer keeps its value when a later read switches to the array space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 pulls SDA low (open drain) |
| busy_in | input | 1 | Internal write cycle in progress |
| wr_push | output | 1 | One-cycle strobe: a write byte is valid |
| wr_space | output | 1 | Space of the pushed byte (0 array, 1 secondary) |
| wr_addr | output | 16 | Target address of the pushed byte |
| wr_data | output | 8 | Pushed byte |
| wr_commit | output | 1 | One-cycle strobe: write the buffered bytes |
| rd_space | output | 1 | Space of the read port |
| rd_addr | output | 16 | Read port address (the pointer) |
| rd_data | input | 8 | Read port data, combinational from rd_addr |

## Verification
The assertions assume a well-behaved master. SDA moves only while SCL is low, except for START and STOP. Each SCL phase lasts at least four system clocks. The master never starts or stops while the slave holds SDA low. The bench master holds every SCL phase for eight system clocks. It changes SDA two clocks into the low phase and samples in the middle of the high phase. It begins a STOP or a repeated START only after the slave has released the line following an acknowledge or a master NACK.

// File: rtl/serial_mem_pkg.sv
package serial_mem_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_CTRL, S_ACKC, S_ADRH, S_ACKH, S_ADRL, S_ACKL,
      S_WDAT, S_ACKW, S_RDAT, S_RACK
   } slv_state_t;

   localparam logic [2:0] CTRL_FAMILY = 3'b101;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   initial begin
      assert (STAGES >= 2) else $error("pin_sync needs two stages or more");
   end

   logic [STAGES-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= {STAGES{RESET_VAL}};
      else        q <= {q[STAGES-2:0], din};
   end

   assign dout = q[STAGES-1];
endmodule

// File: rtl/region_guard.sv
module region_guard #(
   parameter int AW = 13
) (
   input  logic [1:0]    bp,
   input  logic [AW-1:0] addr,
   output logic          hit
);
   initial begin
      assert (AW >= 2) else $error("region_guard needs two address bits or more");
   end

   always_comb begin
      unique case (bp)
         2'b00:   hit = 1'b0;
         2'b01:   hit = &addr[AW-1:AW-2];
         2'b10:   hit = addr[AW-1];
         default: hit = 1'b1;
      endcase
   end
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
   import serial_mem_pkg::*;
#(
   parameter logic [2:0]  STRAP       = 3'b000,
   parameter int          ARRAY_AW    = 13,
   parameter int          PAGE_BYTES  = 32,
   parameter int          OTP_PAGE    = 64,
   parameter logic [15:0] WP_ADDR     = 16'h0401,
   parameter int          SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_in,
   input  logic        sda_in,
   output logic        sda_pull,
   input  logic        busy_in,
   output logic        wr_push,
   output logic        wr_space,
   output logic [15:0] wr_addr,
   output logic [7:0]  wr_data,
   output logic        wr_commit,
   output logic        rd_space,
   output logic [15:0] rd_addr,
   input  logic [7:0]  rd_data
);
   localparam int          PTR_W    = 16;
   localparam int          PG_W     = $clog2(PAGE_BYTES);
   localparam int          OT_W     = $clog2(OTP_PAGE);
   localparam logic [15:0] PG_MASK  = 16'((1 << PG_W) - 1);
   localparam logic [15:0] OT_MASK  = 16'((1 << OT_W) - 1);
   localparam logic [15:0] ARR_MASK = 16'((1 << ARRAY_AW) - 1);

   initial begin
      assert ((1 << PG_W) == PAGE_BYTES) else $error("PAGE_BYTES must be a power of two");
      assert ((1 << OT_W) == OTP_PAGE)   else $error("OTP_PAGE must be a power of two");
      assert (ARRAY_AW <= PTR_W && PG_W < ARRAY_AW) else $error("bad array width");
   end

   // ---------------- line synchronisers ----------------
   logic [1:0] raw_ln, syn_ln;
   assign raw_ln = {sda_in, scl_in};
   for (genvar g = 0; g < 2; g++) begin : g_sync
      pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
         .clk(clk), .rst_n(rst_n), .din(raw_ln[g]), .dout(syn_ln[g]));
   end
   logic scl_s, sda_s, scl_d, sda_d;
   assign scl_s = syn_ln[0];
   assign sda_s = syn_ln[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin scl_d <= 1'b1; sda_d <= 1'b1; end
      else        begin scl_d <= scl_s; sda_d <= sda_s; end
   end

   logic scl_rise, scl_fall, start_det, stop_det;
   assign scl_rise  =  scl_s & ~scl_d;
   assign scl_fall  = ~scl_s &  scl_d;
   assign start_det =  scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  =  scl_s & scl_d & ~sda_d & sda_s;

   // ---------------- protocol state ----------------
   slv_state_t st;
   logic [3:0]       bitcnt;
   logic [7:0]       shreg, tx, hi_byte;
   logic [PTR_W-1:0] ptr;
   logic             space, rw, mack, data_seen, prot_flag, wp_flag;
   logic [1:0]       bp, wp_val;
   logic             prot_hit;

   region_guard #(.AW(ARRAY_AW)) u_guard (
      .bp(bp), .addr(ptr[ARRAY_AW-1:0]), .hit(prot_hit));

   logic             wp_sel, ctrl_ok;
   logic [7:0]       read_val;
   logic [PTR_W-1:0] wr_next, rd_next;

   assign rd_addr  = ptr;
   assign rd_space = space;
   assign wp_sel   = space && (ptr == WP_ADDR);
   assign read_val = wp_sel ? {4'b0000, bp, 2'b00} : rd_data;
   assign ctrl_ok  = (shreg[7:5] == CTRL_FAMILY) && (shreg[3:1] == STRAP) && !busy_in;
   assign wr_next  = space ? ((ptr & ~OT_MASK) | ((ptr + 16'd1) & OT_MASK))
                           : ((ptr & ~PG_MASK) | ((ptr + 16'd1) & PG_MASK));
   assign rd_next  = space ? (ptr + 16'd1) : ((ptr + 16'd1) & ARR_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE;   bitcnt <= '0;  shreg <= '0;  tx <= '0;  hi_byte <= '0;
         ptr <= '0;      space <= 1'b0; rw <= 1'b0;   mack <= 1'b0;
         data_seen <= 1'b0; prot_flag <= 1'b0; wp_flag <= 1'b0;
         bp <= 2'b00;    wp_val <= 2'b00; sda_pull <= 1'b0;
         wr_push <= 1'b0; wr_space <= 1'b0; wr_addr <= '0; wr_data <= '0;
         wr_commit <= 1'b0;
      end else begin
         wr_push   <= 1'b0;
         wr_commit <= 1'b0;
         if (start_det) begin
            st <= S_CTRL; bitcnt <= '0; sda_pull <= 1'b0;
            data_seen <= 1'b0; prot_flag <= 1'b0; wp_flag <= 1'b0;
         end else if (stop_det) begin
            st <= S_IDLE; sda_pull <= 1'b0; data_seen <= 1'b0;
            if (data_seen) begin
               if (!space)       wr_commit <= !prot_flag;
               else if (wp_flag) bp        <= wp_val;
               else              wr_commit <= 1'b1;
            end
         end else begin
            unique case (st)
               S_CTRL, S_ADRH, S_ADRL, S_WDAT: begin
                  if (scl_rise && bitcnt < 4'd8) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     bitcnt   <= '0;
                     sda_pull <= 1'b1;
                     if (st == S_CTRL) begin
                        if (ctrl_ok) begin
                           space <= shreg[4]; rw <= shreg[0]; st <= S_ACKC;
                        end else begin
                           sda_pull <= 1'b0; st <= S_IDLE;
                        end
                     end else if (st == S_ADRH) begin
                        hi_byte <= shreg; st <= S_ACKH;
                     end else if (st == S_ADRL) begin
                        ptr <= {hi_byte, shreg}; st <= S_ACKL;
                     end else begin
                        wr_push <= 1'b1; wr_addr <= ptr; wr_data <= shreg;
                        wr_space <= space; data_seen <= 1'b1;
                        if (!space && prot_hit) prot_flag <= 1'b1;
                        if (wp_sel) begin wp_flag <= 1'b1; wp_val <= shreg[3:2]; end
                        ptr <= wr_next; st <= S_ACKW;
                     end
                  end
               end
               S_ACKC: if (scl_fall) begin
                  if (rw) begin
                     st <= S_RDAT; tx <= read_val; sda_pull <= ~read_val[7];
                  end else begin
                     st <= S_ADRH; sda_pull <= 1'b0;
                  end
               end
               S_ACKH: if (scl_fall) begin st <= S_ADRL; sda_pull <= 1'b0; end
               S_ACKL, S_ACKW: if (scl_fall) begin st <= S_WDAT; sda_pull <= 1'b0; end
               S_RDAT: if (scl_fall) begin
                  if (bitcnt == 4'd7) begin
                     st <= S_RACK; sda_pull <= 1'b0; bitcnt <= '0; ptr <= rd_next;
                  end else begin
                     bitcnt <= bitcnt + 4'd1; tx <= {tx[6:0], 1'b0}; sda_pull <= ~tx[6];
                  end
               end
               S_RACK: begin
                  if (scl_rise) mack <= ~sda_s;
                  else if (scl_fall) begin
                     if (mack) begin
                        st <= S_RDAT; tx <= read_val; sda_pull <= ~read_val[7];
                     end else st <= S_IDLE;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R3
   sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> !scl_s);
   // R3
   commit_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> $past(stop_det));
   // R3
   push_commit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_push, wr_commit}));
   // R8
   bp_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bp) |-> $past(stop_det));
endmodule

// File: tb/serial_mem_slave_tb_top.sv
module serial_mem_slave_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_pull, busy, wr_push, wr_space, wr_commit, rd_space;
   logic [15:0] wr_addr, rd_addr;
   logic [7:0]  wr_data, rd_data;
   wire sda_line = sda_m & ~sda_pull;

   serial_mem_slave dut_i (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
      .sda_pull(sda_pull), .busy_in(busy), .wr_push(wr_push),
      .wr_space(wr_space), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_commit(wr_commit), .rd_space(rd_space), .rd_addr(rd_addr),
      .rd_data(rd_data));

   int tests = 0, fails = 0, commits = 0, busy_cnt = 0;
   bit done = 1'b0;

   function automatic logic [7:0] pat(int a);  return 8'(a * 7 + (a >> 8) + 3); endfunction
   function automatic logic [7:0] opat(int a); return 8'(a * 13 + 81);          endfunction

   // storage behind the page buffer, and the reference model the bench predicts
   logic [7:0] store [0:8191];
   logic [7:0] otp   [0:127];
   logic [7:0] refm  [0:8191];
   logic [15:0] pend_a [$];
   logic [7:0]  pend_d [$];
   logic        pend_s [$];

   assign rd_data = rd_space ? otp[rd_addr[6:0]] : store[rd_addr[12:0]];
   assign busy    = (busy_cnt != 0);

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8192; i++) store[i] = pat(i);
         for (int i = 0; i < 128; i++)  otp[i]   = opat(i);
         busy_cnt <= 0;
      end else begin
         if (wr_push) begin
            pend_a.push_back(wr_addr); pend_d.push_back(wr_data); pend_s.push_back(wr_space);
         end
         if (wr_commit) begin
            for (int k = 0; k < pend_a.size(); k++)
               if (pend_s[k]) otp[pend_a[k][6:0]] = pend_d[k];
               else           store[pend_a[k][12:0]] = pend_d[k];
            pend_a.delete(); pend_d.delete(); pend_s.delete();
            commits  <= commits + 1;
            busy_cnt <= 400;
         end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard: expected bytes queued by the driver, observed bytes by the bus master
   logic [7:0] exp_q [$];
   string      exp_tag [$];
   logic [7:0] obs_q [$];

   always @(negedge clk) begin
      if (obs_q.size() != 0 && exp_q.size() != 0) begin
         logic [7:0] o, e; string t;
         o = obs_q.pop_front(); e = exp_q.pop_front(); t = exp_tag.pop_front();
         check(o == e, t, int'(o), int'(e));
      end
   end

   task automatic expect_byte(input logic [7:0] v, input string tag);
      exp_q.push_back(v); exp_tag.push_back(tag);
   endtask

   // ---------------- bus master ----------------
   task automatic clk_bit(input logic v, output logic smp);
      repeat (2) @(negedge clk); sda_m = v;
      repeat (6) @(negedge clk); scl_m = 1'b1;
      repeat (4) @(negedge clk); smp = sda_line;
      repeat (4) @(negedge clk); scl_m = 1'b0;
   endtask

   task automatic bus_start();
      pend_a.delete(); pend_d.delete(); pend_s.delete();
      repeat (2) @(negedge clk); sda_m = 1'b1;
      repeat (6) @(negedge clk); scl_m = 1'b1;
      repeat (8) @(negedge clk); sda_m = 1'b0;
      repeat (8) @(negedge clk); scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      repeat (2) @(negedge clk); sda_m = 1'b0;
      repeat (6) @(negedge clk); scl_m = 1'b1;
      repeat (8) @(negedge clk); sda_m = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      ack = !s;
   endtask

   task automatic recv_byte(input bit give_ack);
      logic [7:0] b; logic s;
      for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
      clk_bit(give_ack ? 1'b0 : 1'b1, s);
      obs_q.push_back(b);
   endtask

   task automatic wait_ready();
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   // write n bytes from d starting at a; every byte must be acknowledged
   task automatic do_write(input logic [7:0] c, input logic [15:0] a,
                           input logic [7:0] d [4], input int n, input string tag);
      bit ack;
      bus_start();
      send_byte(c, ack);        check(ack, {tag, " ctrl ack"}, ack, 1);
      send_byte(a[15:8], ack);  check(ack, {tag, " addr-hi ack"}, ack, 1);
      send_byte(a[7:0], ack);   check(ack, {tag, " addr-lo ack"}, ack, 1);
      for (int k = 0; k < n; k++) begin
         send_byte(d[k], ack);  check(ack, {tag, " data ack"}, ack, 1);
      end
      bus_stop();
      wait_ready();
   endtask

   // random read of n bytes from a, master ACKs all but the last
   task automatic rand_read(input logic [7:0] c, input logic [15:0] a, input int n);
      bit ack;
      bus_start();
      send_byte(c, ack);        check(ack, "R5 ctrl ack", ack, 1);
      send_byte(a[15:8], ack);
      send_byte(a[7:0], ack);   check(ack, "R5 addr ack", ack, 1);
      bus_start();
      send_byte(c | 8'h01, ack); check(ack, "R5 read ctrl ack", ack, 1);
      for (int k = 0; k < n; k++) recv_byte(k != n - 1);
      bus_stop();
   endtask

   task automatic single(input logic [7:0] c, input logic [15:0] a, input logic [7:0] v, input string tag);
      logic [7:0] d [4];
      d[0] = v; d[1] = 0; d[2] = 0; d[3] = 0;
      do_write(c, a, d, 1, tag);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog actual=hang expected=finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : stim
      bit ack;
      int c0, tries;
      logic [7:0] d [4];
      for (int i = 0; i < 8192; i++) refm[i] = pat(i);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      // R1: idle after reset
      check(sda_pull == 1'b0, "R1 sda released", sda_pull, 0);
      check(commits == 0 && !wr_push, "R1 no commit/push", commits, 0);

      // R2: strap mismatch (1010_101_0) and wrong family (1100_000_0) are refused
      bus_start(); send_byte(8'hAA, ack); check(!ack, "R2 strap mismatch nack", ack, 0);
      send_byte(8'h00, ack); check(!ack, "R2 ignored until START", ack, 0);
      bus_stop();
      bus_start(); send_byte(8'hC0, ack); check(!ack, "R2 bad code nack", ack, 0); bus_stop();
      // R3: matching control byte acked; STOP without data gives no commit
      c0 = commits;
      bus_start(); send_byte(8'hA0, ack); check(ack, "R2 match ack", ack, 1); bus_stop();
      repeat (4) @(negedge clk);
      check(commits == c0, "R3 no commit without data", commits, c0);

      // R3: byte write commits once
      c0 = commits;
      bus_start();
      send_byte(8'hA0, ack); send_byte(8'h01, ack); send_byte(8'h23, ack);
      send_byte(8'h5A, ack); check(ack, "R3 data ack", ack, 1);
      bus_stop();
      refm[16'h0123] = 8'h5A;
      check(commits == c0 + 1, "R3 one commit", commits, c0 + 1);
      // R4: polling during the busy cycle
      bus_start(); send_byte(8'hA0, ack); check(!ack, "R4 busy nack", ack, 0);
      tries = 0;
      while (!ack && tries < 20) begin
         bus_start(); send_byte(8'hA0, ack); tries++;
      end
      check(ack, "R4 ack after busy", ack, 1);
      bus_stop();
      wait_ready();

      // R5: random read; repeated START commits nothing
      c0 = commits;
      expect_byte(refm[16'h0123], "R5 random read");
      rand_read(8'hA0, 16'h0123, 1);
      check(commits == c0, "R5 no commit on restart", commits, c0);

      // R11: current address read continues after 0123h
      expect_byte(refm[16'h0124], "R11 current address");
      bus_start(); send_byte(8'hA1, ack); check(ack, "R11 ctrl ack", ack, 1);
      recv_byte(1'b0); bus_stop();

      // R6: sequential read with rollover 1FFFh -> 0000h
      expect_byte(refm[16'h1FFE], "R6 seq 1FFE");
      expect_byte(refm[16'h1FFF], "R6 seq 1FFF");
      expect_byte(refm[16'h0000], "R6 rollover 0000");
      rand_read(8'hA0, 16'h1FFE, 3);

      // R7: page write from 003Eh wraps inside the 32-byte page
      d[0] = 8'hD0; d[1] = 8'hD1; d[2] = 8'hD2; d[3] = 8'hD3;
      do_write(8'hA0, 16'h003E, d, 4, "R7");
      refm[16'h003E] = 8'hD0; refm[16'h003F] = 8'hD1;
      refm[16'h0020] = 8'hD2; refm[16'h0021] = 8'hD3;
      expect_byte(refm[16'h0020], "R7 wrap 0020");
      expect_byte(refm[16'h0021], "R7 wrap 0021");
      rand_read(8'hA0, 16'h0020, 2);
      expect_byte(refm[16'h003E], "R7 page 003E");
      expect_byte(refm[16'h003F], "R7 page 003F");
      expect_byte(refm[16'h0040], "R7 next page untouched");
      rand_read(8'hA0, 16'h003E, 3);

      // R8: protect register, only bits 3:2 kept, no commit
      c0 = commits;
      single(8'hB0, 16'h0401, 8'hFF, "R8");
      check(commits == c0, "R8 no commit for register", commits, c0);
      expect_byte(8'h0C, "R8 register readback");
      rand_read(8'hB0, 16'h0401, 1);

      // R9 R10: P1:P0 = 01 protects 1800h-1FFFh
      single(8'hB0, 16'h0401, 8'h04, "R8 set 01");
      c0 = commits;
      single(8'hA0, 16'h1800, 8'h77, "R10 protected 01");
      check(commits == c0, "R9 01 suppress 1800", commits, c0);
      single(8'hA0, 16'h17FF, 8'h66, "R9 unprotected 17FF");
      refm[16'h17FF] = 8'h66;
      check(commits == c0 + 1, "R9 01 allows 17FF", commits, c0 + 1);
      // 10 protects 1000h-1FFFh
      single(8'hB0, 16'h0401, 8'h08, "R8 set 10");
      c0 = commits;
      single(8'hA0, 16'h1000, 8'h55, "R10 protected 10");
      check(commits == c0, "R9 10 suppress 1000", commits, c0);
      // 11 protects everything
      single(8'hB0, 16'h0401, 8'h0C, "R8 set 11");
      c0 = commits;
      single(8'hA0, 16'h0000, 8'h44, "R10 protected 11");
      check(commits == c0, "R9 11 suppress 0000", commits, c0);
      // 00 protects nothing
      single(8'hB0, 16'h0401, 8'h00, "R8 set 00");
      single(8'hA0, 16'h1FFF, 8'h33, "R9 unprotected 1FFF");
      refm[16'h1FFF] = 8'h33;
      expect_byte(refm[16'h1800], "R9 1800 kept");
      rand_read(8'hA0, 16'h1800, 1);
      expect_byte(refm[16'h17FF], "R9 17FF written");
      rand_read(8'hA0, 16'h17FF, 1);
      expect_byte(refm[16'h1000], "R9 1000 kept");
      rand_read(8'hA0, 16'h1000, 1);
      expect_byte(refm[16'h0000], "R9 0000 kept");
      rand_read(8'hA0, 16'h0000, 1);
      expect_byte(refm[16'h1FFF], "R9 1FFF written");
      rand_read(8'hA0, 16'h1FFF, 1);

      // R12: secondary space read, then the shared pointer carries into the array
      expect_byte(opat(16'h45), "R12 secondary read");
      rand_read(8'hB0, 16'h0045, 1);
      expect_byte(refm[16'h0046], "R12 shared pointer");
      bus_start(); send_byte(8'hA1, ack); check(ack, "R12 ctrl ack", ack, 1);
      recv_byte(1'b0); bus_stop();

      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule